// File: doc/BRIEF.md
# Registered Two-Way Bus Transceiver

This block joins two parallel buses, A and B, through a non-inverting link. Each direction has its own storage register with its own capture clock. The A-to-B register samples the A input. The B-to-A register samples the B input. An active-low output enable and a direction input together choose which bus, if any, the block drives.

For each direction, a select input picks what is forwarded. It can pass the live value arriving from the opposite bus, or it can pass the value held in that direction's register. Tri-state pins are modelled as three separate signals per bus: an input, an output and an output enable. When a bus is not driven, its output value is forced to zero. The `IDLE_ZERO` parameter can turn this forcing off.

Capture never depends on the output controls. Both registers keep sampling while the block is isolated. A value stored during isolation can be sent out later, once the outputs are enabled again.

Top module: `dual_reg_xcvr`

## Requirements
- R1: An active-low `rst_n` clears both storage registers to all zeros asynchronously. Once cleared, a stored-mode output reads 0x00 without any capture clock edge.
- R2: On a rising edge of `clk_a2b`, the A-to-B register loads `a_in`. On a rising edge of `clk_b2a`, the B-to-A register loads `b_in`. Each clock touches only its own register.
- R3: When `oe_n` is 1 (isolation), `a_oe` and `b_oe` are both 0.
- R4: When `oe_n` is 0, `dir_a2b` = 1 gives `b_oe` = 1 and `a_oe` = 0, and `dir_a2b` = 0 gives `a_oe` = 1 and `b_oe` = 0.
- R5: While B is driven with `sel_b_stored` = 0, `b_out` equals `a_in` bit for bit in the same cycle, with no clock edge in between.
- R6: While B is driven with `sel_b_stored` = 1, `b_out` equals the A-to-B register contents, whatever `a_in` is.
- R7: While A is driven, `sel_a_stored` chooses the source of `a_out`. The value 0 gives live `b_in`. The value 1 gives the B-to-A register contents.
- R8: In isolation, either register, or both on the same edge, can capture. The stored values appear on the buses once the outputs are enabled again.
- R9: Capture also works in transceiver mode. The A-to-B register loads from A while the block drives B.
- R10: An undriven bus output reads 0x00 (default `IDLE_ZERO` = 1).
- R11: `a_oe` and `b_oe` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of both registers |
| clk_a2b | input | 1 | Capture clock for the A-to-B register |
| clk_b2a | input | 1 | Capture clock for the B-to-A register |
| oe_n | input | 1 | Output enable, active low |
| dir_a2b | input | 1 | 1: drive B from the A side; 0: drive A from the B side |
| sel_b_stored | input | 1 | Source for B: 0 live A, 1 stored A-to-B |
| sel_a_stored | input | 1 | Source for A: 0 live B, 1 stored B-to-A |
| a_in | input | W | Value present on bus A |
| b_in | input | W | Value present on bus B |
| a_out | output | W | Value the block drives onto bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_out | output | W | Value the block drives onto bus B |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
The control decode and source select are tried in all sixteen combinations of enable, direction and the two selects. Each combination runs with three A/B data pairs: complementary patterns, all-ones against all-zeros, and single walking bits. These pairs separate a live path from a stored path, show up swapped or inverted bits, and would expose a bus driven from the wrong side. Because the registers are loaded beforehand with values that differ from every live pattern, a stored-mode output can never match a live one by accident. Further sequences capture into one register, then the other, then both during isolation and read them back after the outputs are enabled again. Another sequence captures while B is being driven, and the last one shows the asynchronous clear through a stored-mode output.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

   typedef enum logic {
      SRC_LIVE   = 1'b0,
      SRC_STORED = 1'b1
   } src_sel_e;

   typedef struct packed {
      logic drive_a;
      logic drive_b;
   } drive_t;

   function automatic drive_t decode_drive(input logic oe_n, input logic dir_a2b);
      drive_t d;
      d.drive_b = ~oe_n & dir_a2b;
      d.drive_a = ~oe_n & ~dir_a2b;
      return d;
   endfunction

endpackage

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end
endmodule

// File: rtl/xcvr_drive_ctrl.sv
module xcvr_drive_ctrl
   import xcvr_pkg::*;
(
   input  logic oe_n,
   input  logic dir_a2b,
   output logic drive_a,
   output logic drive_b
);
   drive_t dec;

   always_comb begin
      dec     = decode_drive(oe_n, dir_a2b);
      drive_a = dec.drive_a;
      drive_b = dec.drive_b;
   end
endmodule

// File: rtl/xcvr_out_path.sv
module xcvr_out_path
   import xcvr_pkg::*;
#(
   parameter int W         = 8,
   parameter bit IDLE_ZERO = 1'b1
) (
   input  logic [W-1:0] live,
   input  logic [W-1:0] stored,
   input  logic         sel,
   input  logic         en,
   output logic [W-1:0] data
);
   src_sel_e     src;
   logic [W-1:0] picked;

   always_comb begin
      src    = src_sel_e'(sel);
      picked = (src == SRC_STORED) ? stored : live;
   end

   generate
      if (IDLE_ZERO) begin : g_gate
         assign data = en ? picked : '0;
      end else begin : g_pass
         logic unused_en;
         assign unused_en = en;
         assign data      = picked;
      end
   endgenerate
endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr #(
   parameter int W         = 8,
   parameter bit IDLE_ZERO = 1'b1
) (
   input  logic         rst_n,
   input  logic         clk_a2b,
   input  logic         clk_b2a,
   input  logic         oe_n,
   input  logic         dir_a2b,
   input  logic         sel_b_stored,
   input  logic         sel_a_stored,
   input  logic [W-1:0] a_in,
   input  logic [W-1:0] b_in,
   output logic [W-1:0] a_out,
   output logic         a_oe,
   output logic [W-1:0] b_out,
   output logic         b_oe
);
   localparam int NDIR = 2;   // index 0: A toward B, index 1: B toward A

   generate
      if (W < 1) begin : g_bad_width
         $error("dual_reg_xcvr: W must be at least 1");
      end
   endgenerate

   logic drive_a, drive_b;

   xcvr_drive_ctrl u_ctrl (
      .oe_n    (oe_n),
      .dir_a2b (dir_a2b),
      .drive_a (drive_a),
      .drive_b (drive_b)
   );

   logic [NDIR-1:0]        cap_clk;
   logic [NDIR-1:0][W-1:0] cap_d;
   logic [NDIR-1:0][W-1:0] held;
   logic [NDIR-1:0]        sel;
   logic [NDIR-1:0]        en;
   logic [NDIR-1:0][W-1:0] drv;

   assign cap_clk = {clk_b2a, clk_a2b};
   assign cap_d   = {b_in, a_in};
   assign sel     = {sel_a_stored, sel_b_stored};
   assign en      = {drive_a, drive_b};

   genvar g;
   generate
      for (g = 0; g < NDIR; g++) begin : g_dir
         xcvr_capture_reg #(.W(W)) u_reg (
            .clk   (cap_clk[g]),
            .rst_n (rst_n),
            .d     (cap_d[g]),
            .q     (held[g])
         );
         xcvr_out_path #(.W(W), .IDLE_ZERO(IDLE_ZERO)) u_path (
            .live   (cap_d[g]),
            .stored (held[g]),
            .sel    (sel[g]),
            .en     (en[g]),
            .data   (drv[g])
         );
      end
   endgenerate

   logic [W-1:0] stored_ab, stored_ba;
   assign stored_ab = held[0];
   assign stored_ba = held[1];

   assign b_out = drv[0];
   assign a_out = drv[1];
   assign b_oe  = drive_b;
   assign a_oe  = drive_a;
endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
   parameter int W = 8
) (
   input logic         rst_n,
   input logic         oe_n,
   input logic         dir_a2b,
   input logic         sel_b_stored,
   input logic         sel_a_stored,
   input logic [W-1:0] a_in,
   input logic [W-1:0] b_in,
   input logic [W-1:0] a_out,
   input logic [W-1:0] b_out,
   input logic         a_oe,
   input logic         b_oe,
   input logic [W-1:0] stored_ab,
   input logic [W-1:0] stored_ba
);
   always_comb begin
      if (rst_n) begin
         AST_ENABLES_EXCLUSIVE: assert (!(a_oe && b_oe));                                  // R11
         AST_ISOLATED: assert (!oe_n || (!a_oe && !b_oe));                                  // R3
         AST_DIRECTION: assert (oe_n || (b_oe == dir_a2b && a_oe == !dir_a2b));             // R4
         AST_LIVE_TO_B: assert (!(b_oe && !sel_b_stored) || b_out == a_in);                 // R5
         AST_STORED_TO_B: assert (!(b_oe && sel_b_stored) || b_out == stored_ab);           // R6
         AST_SOURCE_TO_A: assert (!a_oe || a_out == (sel_a_stored ? stored_ba : b_in));     // R7
         AST_IDLE_OUTPUTS: assert ((a_oe || a_out == '0) && (b_oe || b_out == '0));         // R10
      end
   end
endmodule

bind dual_reg_xcvr xcvr_checker #(.W(W)) u_chk (
   .rst_n        (rst_n),
   .oe_n         (oe_n),
   .dir_a2b      (dir_a2b),
   .sel_b_stored (sel_b_stored),
   .sel_a_stored (sel_a_stored),
   .a_in         (a_in),
   .b_in         (b_in),
   .a_out        (a_out),
   .b_out        (b_out),
   .a_oe         (a_oe),
   .b_oe         (b_oe),
   .stored_ab    (stored_ab),
   .stored_ba    (stored_ba)
);

// File: tb/dual_reg_xcvr_test.sv
module dual_reg_xcvr_test;
   localparam int W = 8;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;   // 200 MHz bench clock

   logic         rst_n = 1'b0, clk_a2b = 1'b0, clk_b2a = 1'b0;
   logic         oe_n = 1'b1, dir_a2b = 1'b0, sel_b_stored = 1'b0, sel_a_stored = 1'b0;
   logic [W-1:0] a_in = '0, b_in = '0;
   logic [W-1:0] a_out, b_out;
   logic         a_oe, b_oe;

   dual_reg_xcvr #(.W(W)) uut (
      .rst_n(rst_n), .clk_a2b(clk_a2b), .clk_b2a(clk_b2a), .oe_n(oe_n),
      .dir_a2b(dir_a2b), .sel_b_stored(sel_b_stored), .sel_a_stored(sel_a_stored),
      .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
   );

   typedef struct {
      logic         a_oe, b_oe;
      logic [W-1:0] a_out, b_out;
      string        req;
   } exp_t;

   exp_t         sb[$];
   int           total = 0, bad = 0;
   logic [W-1:0] m_ab = '0, m_ba = '0;   // bench model of stored values
   bit           finished = 1'b0;

   // Driver: set controls and data, push the expected port values.
   task automatic apply(input logic oe, input logic dir, input logic sb_s, input logic sa_s,
                        input logic [W-1:0] a, input logic [W-1:0] b, input string req);
      exp_t e;
      @(posedge clk); #1;
      oe_n = oe; dir_a2b = dir; sel_b_stored = sb_s; sel_a_stored = sa_s;
      a_in = a; b_in = b;
      e.b_oe  = !oe && dir;
      e.a_oe  = !oe && !dir;
      e.b_out = e.b_oe ? (sb_s ? m_ab : a) : '0;
      e.a_out = e.a_oe ? (sa_s ? m_ba : b) : '0;
      e.req   = req;
      sb.push_back(e);
   endtask

   // Capture pulses on either or both register clocks, controls unchanged.
   task automatic capture(input bit do_ab, input bit do_ba,
                          input logic [W-1:0] a, input logic [W-1:0] b);
      @(posedge clk); #1;
      a_in = a; b_in = b;
      #0.5;
      clk_a2b = do_ab; clk_b2a = do_ba;
      if (do_ab) m_ab = a;
      if (do_ba) m_ba = b;
      #0.5;
      clk_a2b = 1'b0; clk_b2a = 1'b0;
   endtask

   // Monitor: compare at the falling edge.
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         total++;
         if (a_oe !== e.a_oe || b_oe !== e.b_oe || a_out !== e.a_out || b_out !== e.b_out) begin
            bad++;
            $display("FAIL %s: got a_oe=%b b_oe=%b a_out=%h b_out=%h exp a_oe=%b b_oe=%b a_out=%h b_out=%h",
                     e.req, a_oe, b_oe, a_out, b_out, e.a_oe, e.b_oe, e.a_out, e.b_out);
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: got hung run, exp completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] pa [3];
      logic [W-1:0] pb [3];
      pa[0] = 8'h5A; pb[0] = 8'hA5;
      pa[1] = 8'hFF; pb[1] = 8'h00;
      pa[2] = 8'h01; pb[2] = 8'h80;

      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // R1: reset state, stored sources read zero
      apply(1'b0, 1'b1, 1'b1, 1'b0, 8'hEE, 8'hDD, "R1 reset stored A-to-B");
      apply(1'b0, 1'b0, 1'b0, 1'b1, 8'hEE, 8'hDD, "R1 reset stored B-to-A");
      // R2: load distinct values, one clock each
      capture(1'b1, 1'b0, 8'h3C, 8'h99);
      apply(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, "R2 B-to-A untouched by clk_a2b");
      capture(1'b0, 1'b1, 8'h77, 8'hC3);
      apply(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, "R2 A-to-B untouched by clk_b2a");
      apply(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, "R2 B-to-A loaded");
      // R3 R4 R5 R6 R7 R10 R11: every control combination with several data pairs
      for (int c = 0; c < 16; c++) begin
         for (int p = 0; p < 3; p++) begin
            apply(c[3], c[2], c[1], c[0], pa[p], pb[p],
                  c[3] ? "R3 R10 isolation" :
                  (c[2] ? (c[1] ? "R6 R4 R11 stored to B" : "R5 R4 R11 live to B")
                        : (c[0] ? "R7 R4 R11 stored to A" : "R7 R4 R11 live to A")));
         end
      end
      // R8: capture during isolation, one then the other then both together
      apply(1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, "R8 isolated");
      capture(1'b1, 1'b0, 8'h96, 8'h42);
      apply(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, "R8 isolated A-to-B capture");
      apply(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, "R8 B-to-A kept while isolated");
      apply(1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, "R8 isolated");
      capture(1'b0, 1'b1, 8'h24, 8'h69);
      capture(1'b1, 1'b1, 8'h11, 8'h22);
      apply(1'b0, 1'b1, 1'b1, 1'b1, 8'hF0, 8'h0F, "R8 both captured, out on B");
      apply(1'b0, 1'b0, 1'b1, 1'b1, 8'hF0, 8'h0F, "R8 both captured, out on A");
      // R9: capture from A while B is driven live
      apply(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, "R9 driving B");
      capture(1'b1, 1'b0, 8'h7E, 8'h00);
      apply(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, "R9 captured while driving");
      // R1: asynchronous clear with no capture clock
      @(posedge clk); #1; rst_n = 1'b0; m_ab = '0; m_ba = '0;
      #1; rst_n = 1'b1;
      apply(1'b0, 1'b1, 1'b1, 1'b0, 8'hAB, 8'hCD, "R1 async clear A-to-B");
      apply(1'b0, 1'b0, 1'b0, 1'b1, 8'hAB, 8'hCD, "R1 async clear B-to-A");

      repeat (3) @(posedge clk);
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule